// File: doc/BRIEF.md
# Event-Triggered DMA Channel Engine

This block is one DMA channel. It copies 32-bit words from a source address to a destination address through a single word-wide bus-master port with a ready handshake. Software sets it up through a small write-only register port. The registers hold two addresses, a total word budget, a per-run word count, a burst interval with a prescaler, a fill word and a control word. Runs are started by the channel's enable bit in immediate mode, or otherwise by one of sixteen trigger inputs.

Inside a run, words move in bursts of a power-of-two length. The bus request is not released between the words of a burst. Between two bursts, an interval timer clocked through a prescaler spaces them apart. Each side can step its address up by 4, step it down by 4, or hold it. A fill mode writes the fill word at every destination and never reads a source. A completion interrupt pulses for one cycle when the channel turns itself off.

Top module: `dma_chan_engine`

## Requirements
- R1: While `rst_ni` is low and after it is released, `busy_o`, `bus_req_o` and `irq_o` are 0.
- R2: Every address on `bus_addr_o` has bits [1:0] equal to 0. Those bits of a written address value are dropped.
- R3: A write to the source register (`cfg_sel_i`=0) or the destination register (`cfg_sel_i`=1) loads that side's working address at once. The next word on that side uses the new address.
- R4: Control bits [14:13] set the source address mode and bits [11:10] set the destination address mode. Value 0 adds 4 per word, value 1 subtracts 4 per word, and value 2 holds the address.
- R5: Source mode 3 is fill mode. In fill mode no read is issued, and every written word equals the fill register (`cfg_sel_i`=5).
- R6: Each word is a read at the source (`bus_we_o`=0) followed by a write at the destination (`bus_we_o`=1). While `bus_req_o`=1 and `bus_ready_i`=0, the address, direction and write data hold steady.
- R7: A burst is 2^x words, where x is control bits [19:16]. The last burst of a run is shortened to the words that remain. `bus_req_o` stays high from the first word of a burst to the last.
- R8: The interval register (`cfg_sel_i`=4) holds count n in bits [15:0] and the prescaler p in bits [17:16], giving a divider d of 1, 4, 16 or 64. Between two bursts of one run, `bus_req_o` is low for exactly n*d+1 cycles.
- R9: Immediate mode is control bit 28. Setting control bit 31 (enable) with bit 28 set moves the per-run count (`cfg_sel_i`=3) at once. `busy_o` then drops to 0, whatever the total count and the repeat bit hold.
- R10: Repeating mode is control bit 29. Each pulse on `trig_i[s]` starts one run, where s is control bits [27:24]. The channel stays busy until software writes bit 31 to 0.
- R11: With bits 28 and 29 both clear, each selected trigger starts one run. The channel clears `busy_o` when the words moved since enable reach the total count (`cfg_sel_i`=2).
- R12: Control bit 15 restores the source working address, and bit 12 the destination working address, to the last written value at the start of each run. With the bit clear, that side continues from where the previous run stopped.
- R13: `irq_o` pulses for one cycle when the channel clears its own busy bit, and only if control bit 30 is set.
- R14: A trigger pulse is ignored while a run is in progress. A pulse on a trigger input that is not selected never starts a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 3 | Register select: 0 src, 1 dst, 2 total, 3 run count, 4 interval, 5 fill, 6 control |
| cfg_wdata_i | input | 32 | Register write data |
| trig_i | input | 16 | Start-event inputs |
| bus_req_o | output | 1 | Bus transfer request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 32 | Word-aligned bus address |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data, taken when ready is high |
| bus_ready_i | input | 1 | Transfer accepted this cycle |
| busy_o | output | 1 | Enable/busy state |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
A start event and an active run can land in the same cycle. The bench provokes this in repeating mode: it waits until the first request of a run is on the bus, then pulses the selected trigger again while that run is still moving words. The scoreboard judges the outcome. Any write beyond the one expected run is reported as unexpected, and the next real trigger must begin again from the reloaded source address.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_GAP} dma_state_e;
  typedef enum logic [1:0] {AM_INC = 2'd0, AM_DEC = 2'd1, AM_FIX = 2'd2, AM_NONE = 2'd3} addr_mode_e;
  localparam logic [2:0] SEL_SRC  = 3'd0;
  localparam logic [2:0] SEL_DST  = 3'd1;
  localparam logic [2:0] SEL_TOT  = 3'd2;
  localparam logic [2:0] SEL_WCNT = 3'd3;
  localparam logic [2:0] SEL_IVAL = 3'd4;
  localparam logic [2:0] SEL_FILL = 3'd5;
  localparam logic [2:0] SEL_CTRL = 3'd6;
endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen import dma_chan_pkg::*; #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          reload_i,
  input  logic          step_i,
  input  addr_mode_e    mode_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] base_q, addr_q;
  logic [AW-1:0] aligned;

  assign aligned = {load_val_i[AW-1:2], 2'b00};
  assign addr_o  = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      addr_q <= '0;
    end else if (load_i) begin
      base_q <= aligned;
      addr_q <= aligned;
    end else if (reload_i) begin
      addr_q <= base_q;
    end else if (step_i) begin
      case (mode_i)
        AM_INC:  addr_q <= addr_q + AW'(4);
        AM_DEC:  addr_q <= addr_q - AW'(4);
        default: addr_q <= addr_q;
      endcase
    end
  end

  assert_aligned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_o[1:0] == 2'b00);
  assert_fixed_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i && !reload_i && (mode_i == AM_FIX) |=> $stable(addr_o));
endmodule

// File: rtl/dma_gap_timer.sv
module dma_gap_timer #(
  parameter int CW = 16,
  parameter int PW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    presc_i,
  input  logic [CW-1:0] ival_i,
  output logic          done_o
);
  logic [CW-1:0] icnt_q;
  logic [PW-1:0] pcnt_q, div_m1_q, div_m1;

  always_comb begin
    case (presc_i)
      2'd0:    div_m1 = PW'(0);
      2'd1:    div_m1 = PW'(3);
      2'd2:    div_m1 = PW'(15);
      default: div_m1 = PW'(63);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      icnt_q   <= '0;
      pcnt_q   <= '0;
      div_m1_q <= '0;
    end else if (start_i) begin
      icnt_q   <= ival_i;
      pcnt_q   <= '0;
      div_m1_q <= div_m1;
    end else if (icnt_q != '0) begin
      if (pcnt_q == div_m1_q) begin
        pcnt_q <= '0;
        icnt_q <= icnt_q - 1'b1;
      end else begin
        pcnt_q <= pcnt_q + 1'b1;
      end
    end
  end

  assign done_o = (icnt_q == '0);

  assert_no_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && (icnt_q == '0) |=> (icnt_q == '0));
  assert_presc_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcnt_q <= div_m1_q);
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine import dma_chan_pkg::*; #(
  parameter int AW    = 32,
  parameter int WCW   = 24,
  parameter int TCW   = 28,
  parameter int IW    = 16,
  parameter int NTRIG = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_sel_i,
  input  logic [31:0]      cfg_wdata_i,
  input  logic [NTRIG-1:0] trig_i,
  output logic             bus_req_o,
  output logic             bus_we_o,
  output logic [AW-1:0]    bus_addr_o,
  output logic [31:0]      bus_wdata_o,
  input  logic [31:0]      bus_rdata_i,
  input  logic             bus_ready_i,
  output logic             busy_o,
  output logic             irq_o
);
  localparam int SELW = (NTRIG > 1) ? $clog2(NTRIG) : 1;

  dma_state_e     st_q;
  logic [TCW-1:0] total_q, accum_q, accum_nx;
  logic [WCW-1:0] wcnt_q, run_left_q, burst_left_q;
  logic [IW-1:0]  ival_q;
  logic [1:0]     presc_q;
  logic [31:0]    fill_q, ctrl_q, data_q;
  logic           en_q, irq_q;
  addr_mode_e     r_smode, r_dmode;
  logic [3:0]     r_bx;
  logic           r_imm, r_rep, r_fill;
  logic [AW-1:0]  src_addr, dst_addr;
  logic           start_go, trig_hit, step_s, step_d, tmr_start, tmr_done;
  logic [SELW-1:0] trig_sel;

  function automatic logic [WCW-1:0] burst_len(input logic [3:0] bx, input logic [WCW-1:0] left);
    logic [WCW-1:0] full;
    full = WCW'(1) << bx;
    return (left < full) ? left : full;
  endfunction

  assign trig_sel  = ctrl_q[24 +: SELW];
  assign trig_hit  = trig_i[trig_sel];
  assign start_go  = (st_q == ST_IDLE) && en_q && (wcnt_q != '0) && (ctrl_q[28] || trig_hit);
  assign step_s    = (st_q == ST_RD) && bus_ready_i;
  assign step_d    = (st_q == ST_WR) && bus_ready_i;
  assign tmr_start = step_d && (run_left_q != WCW'(1)) && (burst_left_q == WCW'(1));
  assign accum_nx  = accum_q + 1'b1;

  assign bus_req_o   = (st_q == ST_RD) || (st_q == ST_WR);
  assign bus_we_o    = (st_q == ST_WR);
  assign bus_addr_o  = (st_q == ST_WR) ? dst_addr : src_addr;
  assign bus_wdata_o = r_fill ? fill_q : data_q;
  assign busy_o      = en_q;
  assign irq_o       = irq_q;

  dma_addr_gen #(.AW(AW)) u_src (
    .clk_i, .rst_ni,
    .load_i     (cfg_we_i && cfg_sel_i == SEL_SRC),
    .load_val_i (cfg_wdata_i[AW-1:0]),
    .reload_i   (start_go && ctrl_q[15]),
    .step_i     (step_s),
    .mode_i     (r_smode),
    .addr_o     (src_addr)
  );

  dma_addr_gen #(.AW(AW)) u_dst (
    .clk_i, .rst_ni,
    .load_i     (cfg_we_i && cfg_sel_i == SEL_DST),
    .load_val_i (cfg_wdata_i[AW-1:0]),
    .reload_i   (start_go && ctrl_q[12]),
    .step_i     (step_d),
    .mode_i     (r_dmode),
    .addr_o     (dst_addr)
  );

  dma_gap_timer #(.CW(IW)) u_gap (
    .clk_i, .rst_ni,
    .start_i (tmr_start),
    .presc_i (presc_q),
    .ival_i  (ival_q),
    .done_o  (tmr_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      total_q <= '0; accum_q <= '0; wcnt_q <= '0;
      run_left_q <= '0; burst_left_q <= '0;
      ival_q <= '0; presc_q <= '0; fill_q <= '0; ctrl_q <= '0; data_q <= '0;
      en_q <= 1'b0; irq_q <= 1'b0;
      r_smode <= AM_INC; r_dmode <= AM_INC; r_bx <= '0;
      r_imm <= 1'b0; r_rep <= 1'b0; r_fill <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_go) begin
          r_smode      <= addr_mode_e'(ctrl_q[14:13]);
          r_dmode      <= addr_mode_e'(ctrl_q[11:10]);
          r_bx         <= ctrl_q[19:16];
          r_imm        <= ctrl_q[28];
          r_rep        <= ctrl_q[29];
          r_fill       <= (ctrl_q[14:13] == 2'd3);
          run_left_q   <= wcnt_q;
          burst_left_q <= burst_len(ctrl_q[19:16], wcnt_q);
          st_q         <= (ctrl_q[14:13] == 2'd3) ? ST_WR : ST_RD;
        end
        ST_RD: if (bus_ready_i) begin
          data_q <= bus_rdata_i;
          st_q   <= ST_WR;
        end
        ST_WR: if (bus_ready_i) begin
          run_left_q   <= run_left_q - 1'b1;
          burst_left_q <= burst_left_q - 1'b1;
          accum_q      <= accum_nx;
          if (run_left_q == WCW'(1)) begin
            st_q <= ST_IDLE;
            if (r_imm || (!r_rep && accum_nx >= total_q)) begin
              en_q  <= 1'b0;
              irq_q <= ctrl_q[30];
            end
          end else if (burst_left_q == WCW'(1)) begin
            st_q <= en_q ? ST_GAP : ST_IDLE;
          end else begin
            st_q <= r_fill ? ST_WR : ST_RD;
          end
        end
        ST_GAP: begin
          if (!en_q) st_q <= ST_IDLE;
          else if (tmr_done) begin
            burst_left_q <= burst_len(r_bx, run_left_q);
            st_q         <= r_fill ? ST_WR : ST_RD;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
      // software writes take priority over self-disable
      if (cfg_we_i) begin
        case (cfg_sel_i)
          SEL_TOT:  total_q <= cfg_wdata_i[TCW-1:0];
          SEL_WCNT: wcnt_q  <= cfg_wdata_i[WCW-1:0];
          SEL_IVAL: begin
            ival_q  <= cfg_wdata_i[IW-1:0];
            presc_q <= cfg_wdata_i[17:16];
          end
          SEL_FILL: fill_q <= cfg_wdata_i;
          SEL_CTRL: begin
            ctrl_q <= cfg_wdata_i;
            en_q   <= cfg_wdata_i[31];
            if (cfg_wdata_i[31] && !en_q) accum_q <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  assert_bus_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ready_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o));
  assert_fill_noread_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && r_fill |-> bus_we_o);
  assert_irq_off_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !busy_o || $past(cfg_we_i && cfg_sel_i == SEL_CTRL));
  assert_irq_pulse_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

// File: tb/tb_dma_chan_engine.sv
module tb_dma_chan_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [15:0] trig = '0;
  logic        bus_req, bus_we, bus_ready, busy, irq;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  assign bus_rdata = mem_word(bus_addr);

  dma_chan_engine dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .trig_i(trig),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .bus_ready_i(bus_ready),
    .busy_o(busy), .irq_o(irq)
  );

  int n_chk = 0, n_bad = 0;
  logic [63:0] exp_q[$];
  string cur_tag = "R3";
  int n_writes = 0, n_reads = 0, n_irq = 0, n_gaps = 0;
  int low_cnt = 0, gap_exp = 0;
  bit gap_chk = 0, after_wr = 0, stall_en = 0, done = 0;
  logic [7:0] lfsr = 8'hA7;
  bit pend = 0;
  logic [31:0] p_addr, p_data;
  logic p_we;

  logic [31:0] m_src, m_dst, m_fill;
  int m_smode, m_dmode;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial bus_ready = 1'b1;

  // monitor: ready generation, handshake tracking, scoreboard
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    bus_ready = stall_en ? (lfsr[0] | lfsr[2]) : 1'b1;
    if (rst_n) begin
      if (irq) n_irq++;
      if (pend)
        check(bus_req && bus_addr == p_addr && bus_we == p_we && (!p_we || bus_wdata == p_data),
              "R6", bus_addr, p_addr);
      pend = bus_req && !bus_ready;
      p_addr = bus_addr; p_we = bus_we; p_data = bus_wdata;
      if (!bus_req) low_cnt++;
      else begin
        if (low_cnt > 0 && after_wr && gap_chk) begin
          n_gaps++;
          check(low_cnt == gap_exp, "R8", low_cnt, gap_exp);
        end
        if (low_cnt > 0) after_wr = 0;
        low_cnt = 0;
      end
      if (bus_req && bus_ready) begin
        if (bus_we) begin
          n_writes++;
          after_wr = 1;
          if (exp_q.size() == 0) check(0, {cur_tag, " unexpected write"}, bus_addr, 0);
          else begin
            logic [63:0] e;
            e = exp_q.pop_front();
            check(bus_addr == e[63:32], cur_tag, bus_addr, e[63:32]);
            check(bus_wdata == e[31:0], cur_tag, bus_wdata, e[31:0]);
          end
        end else n_reads++;
      end
    end
  end

  task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] mk_ctrl(input bit en, input bit ie, input bit rep, input bit imm,
      input int sel, input int bx, input bit srl, input int smode, input bit drl, input int dmode);
    return {en, ie, rep, imm, 4'(sel), 4'd0, 4'(bx), srl, 2'(smode), drl, 2'(dmode), 10'd0};
  endfunction

  function automatic logic [31:0] step_addr(input logic [31:0] a, input int mode);
    if (mode == 0) return a + 32'd4;
    if (mode == 1) return a - 32'd4;
    return a;
  endfunction

  // driver: pushes expected writes for one run
  task automatic expect_run(input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] d;
      d = (m_smode == 3) ? m_fill : mem_word(m_src);
      exp_q.push_back({m_dst, d});
      if (m_smode != 3) m_src = step_addr(m_src, m_smode);
      m_dst = step_addr(m_dst, m_dmode);
    end
  endtask

  task automatic wait_idle(input string tag);
    int t;
    t = 0;
    while ((exp_q.size() != 0 || bus_req) && t < 5000) begin
      @(negedge clk); t++;
    end
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, {tag, " words pending"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    trig[idx] = 1'b1;
    @(negedge clk);
    trig[idx] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int w0, i0, r0;
    repeat (3) @(negedge clk);
    check(!busy && !bus_req && !irq, "R1 in reset", {busy, bus_req, irq}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy, "R1 busy", busy, 0);
    check(!bus_req, "R1 req", bus_req, 0);
    check(!irq && n_irq == 0, "R1 irq", n_irq, 0);

    // T1: immediate, increment both, bursts of 2, interval 2 at /4, unaligned source
    stall_en = 1; cur_tag = "R3";
    cfg_write(3'd0, 32'h0000_1003);           // R2: low bits dropped
    cfg_write(3'd1, 32'h0000_2000);
    cfg_write(3'd2, 32'd1);                   // total ignored in immediate (R9)
    cfg_write(3'd3, 32'd5);
    cfg_write(3'd4, (32'd1 << 16) | 32'd2);
    m_src = 32'h1000; m_dst = 32'h2000; m_smode = 0; m_dmode = 0;
    expect_run(5);
    gap_exp = 2 * 4 + 1; gap_chk = 1; after_wr = 0; n_gaps = 0;
    cfg_write(3'd6, mk_ctrl(1, 1, 0, 1, 0, 1, 0, 0, 0, 0));
    wait_idle("R3");
    gap_chk = 0;
    check(n_gaps == 2, "R7 burst count", n_gaps, 2);
    check(!busy, "R9 busy cleared", busy, 0);
    check(n_irq == 1, "R13 irq on finish", n_irq, 1);

    // T2: decrement both, burst of 4 shortened to 3, no irq
    cur_tag = "R4";
    cfg_write(3'd0, 32'h3000);
    cfg_write(3'd1, 32'h4000);
    cfg_write(3'd3, 32'd3);
    cfg_write(3'd4, 32'd0);
    m_src = 32'h3000; m_dst = 32'h4000; m_smode = 1; m_dmode = 1;
    expect_run(3);
    cfg_write(3'd6, mk_ctrl(1, 0, 0, 1, 0, 2, 0, 1, 0, 1));
    wait_idle("R4");
    check(!busy, "R9 busy cleared", busy, 0);
    check(n_irq == 1, "R13 no irq without enable", n_irq, 1);

    // T3: fill mode, fixed destination
    cur_tag = "R5";
    r0 = n_reads;
    cfg_write(3'd5, 32'hCAFE_F00D);
    cfg_write(3'd1, 32'h5000);
    cfg_write(3'd3, 32'd4);
    m_fill = 32'hCAFE_F00D; m_dst = 32'h5000; m_smode = 3; m_dmode = 2;
    expect_run(4);
    cfg_write(3'd6, mk_ctrl(1, 1, 0, 1, 0, 3, 0, 3, 0, 2));
    wait_idle("R5");
    check(n_reads == r0, "R5 no reads", n_reads - r0, 0);
    check(n_irq == 2, "R13 irq", n_irq, 2);

    // T4: count-limited, trigger 5, no reload
    cur_tag = "R11";
    cfg_write(3'd0, 32'h6000);
    cfg_write(3'd1, 32'h7000);
    cfg_write(3'd2, 32'd6);
    cfg_write(3'd3, 32'd3);
    m_src = 32'h6000; m_dst = 32'h7000; m_smode = 0; m_dmode = 0;
    w0 = n_writes;
    cfg_write(3'd6, mk_ctrl(1, 1, 0, 0, 5, 0, 0, 0, 0, 0));
    repeat (10) @(negedge clk);
    check(busy && n_writes == w0, "R11 waits for event", n_writes - w0, 0);
    pulse(3);
    repeat (20) @(negedge clk);
    check(n_writes == w0, "R14 unselected trigger", n_writes - w0, 0);
    expect_run(3);
    pulse(5);
    wait_idle("R11");
    check(busy, "R11 still busy", busy, 1);
    cur_tag = "R12";
    expect_run(3);                           // continues from 0x600C / 0x700C
    pulse(5);
    wait_idle("R12");
    check(!busy, "R11 total reached", busy, 0);
    check(n_irq == 3, "R13 irq", n_irq, 3);

    // T5: repeating, trigger 2, source reload only
    cur_tag = "R14";
    cfg_write(3'd0, 32'h8000);
    cfg_write(3'd1, 32'h9000);
    cfg_write(3'd3, 32'd2);
    m_src = 32'h8000; m_dst = 32'h9000; m_smode = 0; m_dmode = 0;
    cfg_write(3'd6, mk_ctrl(1, 1, 1, 0, 2, 0, 1, 0, 0, 0));
    expect_run(2);
    pulse(2);
    while (!bus_req) @(negedge clk);
    pulse(2);                                // lands mid-run: ignored
    wait_idle("R14");
    check(busy, "R10 stays busy", busy, 1);
    cur_tag = "R12";
    m_src = 32'h8000;                        // source reloaded, destination continues
    expect_run(2);
    pulse(2);
    wait_idle("R12");
    check(busy, "R10 stays busy", busy, 1);
    check(n_irq == 3, "R13 no irq in repeat", n_irq, 3);
    i0 = n_writes;
    cfg_write(3'd6, 32'd0);
    repeat (3) @(negedge clk);
    check(!busy, "R10 software clear", busy, 0);
    pulse(2);
    repeat (20) @(negedge clk);
    check(n_writes == i0, "R10 disabled ignores trigger", n_writes - i0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule